// File: doc/BRIEF.md
# Parallel Bus Sampler and Word Assembler

This block watches a synchronous parallel bus (one bus clock line and up to eight data lines) with a much faster system clock, as the front end of a logic analyser would. The bus lines first pass through a two-flop synchronizer. A capture is then taken on the selected edge of the bus clock. When the bus clock is marked as absent, any change on the data lines takes a capture instead. A free-running sample counter stamps every capture.

Item reporting runs one capture behind. The first item after reset is held and produces no output. Each later capture reports the held item, with a start stamp at that item's own capture and an end stamp at the current capture, and then holds the new item. In parallel, consecutive items are packed into words of one to four items, in either of two orders. A word carries the stamp of its first item's capture and of the capture that completes it.

Top module: `par_bus_sampler`

## Requirements
- R1: A synchronized bus sample equal to the previous one (bus clock and data together) never triggers a capture. After reset the reference sample is bus clock 0, data 0.
- R2: With `clk_present_i`=1 and `edge_fall_i`=0, only a 0-to-1 change of the bus clock captures. A falling bus clock, or a data change while the bus clock is steady, captures nothing.
- R3: With `clk_present_i`=1 and `edge_fall_i`=1, only a 1-to-0 change of the bus clock captures. The rising change captures nothing.
- R4: With `clk_present_i`=0, every change of the data lines captures, and a change of the bus clock alone captures nothing.
- R5: Data line i lands in bit i of the item. The first capture after reset raises no `item_valid_o`. Each later capture reports the previously held item, with `item_ts_start_o` equal to that item's capture stamp and `item_ts_end_o` equal to the current capture stamp.
- R6: The effective items-per-word N is `items_per_word_i`, with 0 read as 1 and values above 4 read as 4. A word is emitted on the Nth capture, and the count then restarts at zero.
- R7: With `order_msb_first_i`=1, item k of a word (k from 0) sits at bits [8(N-1-k)+7 : 8(N-1-k)] of `word_data_o`. All bits above 8N are zero.
- R8: With `order_msb_first_i`=0, item k sits at bits [8k+7 : 8k].
- R9: `word_ts_start_o` is the stamp of the capture of the word's first item. `word_ts_end_o` is the stamp of the capture that completes the word.
- R10: A change of any configuration input (clock-present, edge select, order, items-per-word) discards the items of a partly assembled word.
- R11: While reset is asserted, both valid strobes are low and the held item is cleared, so the first capture after reset reports no item.
- R12: `item_valid_o` and `word_valid_o` are one-cycle strobes. They rise on the third rising system-clock edge after a bus input change that causes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_clk_i | input | 1 | Bus clock line (asynchronous) |
| bus_data_i | input | DATA_W | Bus data lines (asynchronous) |
| clk_present_i | input | 1 | 1: capture on bus clock edge; 0: capture on any data change |
| edge_fall_i | input | 1 | 0: rising bus clock edge; 1: falling edge |
| items_per_word_i | input | $clog2(MAX_ITEMS+1) | Items per word, clamped to 1..MAX_ITEMS |
| order_msb_first_i | input | 1 | 1: first item at most significant slot; 0: at least significant |
| item_valid_o | output | 1 | One-cycle strobe for a reported item |
| item_data_o | output | DATA_W | Reported item value |
| item_ts_start_o | output | TS_W | Capture stamp of the reported item |
| item_ts_end_o | output | TS_W | Capture stamp of the capture that reported it |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_data_o | output | DATA_W*MAX_ITEMS | Packed word |
| word_ts_start_o | output | TS_W | Stamp of the word's first capture |
| word_ts_end_o | output | TS_W | Stamp of the word's completing capture |

## Verification
The bench targets the opposite bus clock edge, data wiggles while the bus clock is steady, and repeated identical samples. A design that compared only data, or only clock levels, would then emit extra words. It checks that the first capture after reset stays silent and that item spans equal the bench's own gap between captures; an off-by-one in the held-item pipeline would show a wrong value or a shifted span. Both packing orders are run with three and four items, and the items-per-word values 0 and 7 are clamped; a reversed offset or a missing clamp gives the wrong packed word or the wrong number of words. A configuration change in the middle of a word must discard the stale item. A design that kept it would pack the old item and emit a wrong word value.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic {
    ORD_LSB_FIRST = 1'b0,
    ORD_MSB_FIRST = 1'b1
  } word_order_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/psw_capture_detect.sv
module psw_capture_detect
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_clk_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              clk_present_i,
  input  logic              edge_fall_i,
  output logic              cap_o,
  output logic [DATA_W-1:0] cap_data_o
);
  logic              prev_clk_q,  prev_clk_d;
  logic [DATA_W-1:0] prev_data_q, prev_data_d;
  logic              clk_moved, data_moved, edge_match, prev_en;
  edge_sel_e         edge_sel;

  always_comb begin
    edge_sel    = edge_sel_e'(edge_fall_i);
    clk_moved   = (smp_clk_i != prev_clk_q);
    data_moved  = (smp_data_i != prev_data_q);
    edge_match  = (edge_sel == EDGE_RISE) ? smp_clk_i : !smp_clk_i;
    cap_o       = clk_present_i ? (clk_moved && edge_match) : data_moved;
    cap_data_o  = smp_data_i;
    prev_en     = clk_moved || data_moved;
    prev_clk_d  = smp_clk_i;
    prev_data_d = smp_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk_q  <= 1'b0;
      prev_data_q <= '0;
    end else if (prev_en) begin
      prev_clk_q  <= prev_clk_d;
      prev_data_q <= prev_data_d;
    end
  end

  AST_STABLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(smp_clk_i) && $stable(smp_data_i)) |-> !cap_o); // R1

  AST_RISE_MODE_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_present_i && !edge_fall_i && !smp_clk_i) |-> !cap_o); // R2

  AST_FALL_MODE_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_present_i && edge_fall_i && smp_clk_i) |-> !cap_o); // R3
endmodule

// File: rtl/psw_item_hold.sv
module psw_item_hold #(
  parameter int DATA_W = 8,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              item_valid_o,
  output logic [DATA_W-1:0] item_data_o,
  output logic [TS_W-1:0]   item_ts_start_o,
  output logic [TS_W-1:0]   item_ts_end_o
);
  logic              held_vld_q,  held_vld_d;
  logic [DATA_W-1:0] held_data_q, held_data_d;
  logic [TS_W-1:0]   held_ts_q,   held_ts_d;
  logic              out_vld_q,   out_vld_d;
  logic [DATA_W-1:0] out_data_q,  out_data_d;
  logic [TS_W-1:0]   out_ts0_q,   out_ts0_d;
  logic [TS_W-1:0]   out_ts1_q,   out_ts1_d;
  logic              hold_en, out_en;

  always_comb begin
    hold_en     = cap_i;
    held_vld_d  = 1'b1;
    held_data_d = cap_data_i;
    held_ts_d   = ts_i;
    out_vld_d   = cap_i && held_vld_q;
    out_en      = out_vld_d;
    out_data_d  = held_data_q;
    out_ts0_d   = held_ts_q;
    out_ts1_d   = ts_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld_q  <= 1'b0;
      held_data_q <= '0;
      held_ts_q   <= '0;
    end else if (hold_en) begin
      held_vld_q  <= held_vld_d;
      held_data_q <= held_data_d;
      held_ts_q   <= held_ts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= out_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data_q <= '0;
      out_ts0_q  <= '0;
      out_ts1_q  <= '0;
    end else if (out_en) begin
      out_data_q <= out_data_d;
      out_ts0_q  <= out_ts0_d;
      out_ts1_q  <= out_ts1_d;
    end
  end

  assign item_valid_o    = out_vld_q;
  assign item_data_o     = out_data_q;
  assign item_ts_start_o = out_ts0_q;
  assign item_ts_end_o   = out_ts1_q;

  AST_FIRST_ITEM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !held_vld_q) |=> !item_valid_o); // R5

  AST_ITEM_SPAN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid_o |-> (item_ts_end_o != item_ts_start_o)); // R5
endmodule

// File: rtl/psw_word_pack.sv
module psw_word_pack
  import psw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_ITEMS = 4,
  parameter int TS_W      = 32,
  localparam int CNT_W    = $clog2(MAX_ITEMS + 1),
  localparam int WORD_W   = DATA_W * MAX_ITEMS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [CNT_W-1:0]  ipw_i,
  input  logic              order_i,
  input  logic              cfg_chg_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [TS_W-1:0]   word_ts_start_o,
  output logic [TS_W-1:0]   word_ts_end_o
);
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [WORD_W-1:0] acc_q,   acc_d;
  logic [TS_W-1:0]   first_q, first_d;
  logic              cnt_en,  acc_en;
  logic [CNT_W-1:0]  ipw_eff, slot_k;
  logic              last_item;
  word_order_e       order;
  int unsigned       slot_pos;
  logic [WORD_W-1:0] placed;

  logic              wv_q,  wv_d;
  logic [WORD_W-1:0] wd_q,  wd_d;
  logic [TS_W-1:0]   wt0_q, wt0_d;
  logic [TS_W-1:0]   wt1_q, wt1_d;
  logic              wout_en;

  always_comb begin
    if (ipw_i == '0)                          ipw_eff = CNT_W'(1);
    else if (ipw_i > CNT_W'(MAX_ITEMS))       ipw_eff = CNT_W'(MAX_ITEMS);
    else                                      ipw_eff = ipw_i;
    order    = word_order_e'(order_i);
    slot_k   = cfg_chg_i ? '0 : cnt_q;
    slot_pos = (order == ORD_MSB_FIRST)
             ? (int'(ipw_eff) - 1 - int'(slot_k))
             : int'(slot_k);
    placed   = {{(WORD_W-DATA_W){1'b0}}, cap_data_i} << (slot_pos * DATA_W);
    last_item = ((slot_k + 1'b1) == ipw_eff);

    acc_d   = ((slot_k == '0) ? '0 : acc_q) | placed;
    first_d = (slot_k == '0) ? ts_i : first_q;
    acc_en  = cap_i;

    cnt_en  = cap_i || cfg_chg_i;
    if (cap_i) cnt_d = last_item ? '0 : (slot_k + 1'b1);
    else       cnt_d = '0;

    wv_d    = cap_i && last_item;
    wout_en = wv_d;
    wd_d    = acc_d;
    wt0_d   = first_d;
    wt1_d   = ts_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      first_q <= '0;
    end else if (acc_en) begin
      acc_q   <= acc_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
    end else begin
      wv_q <= wv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= '0;
      wt0_q <= '0;
      wt1_q <= '0;
    end else if (wout_en) begin
      wd_q  <= wd_d;
      wt0_q <= wt0_d;
      wt1_q <= wt1_d;
    end
  end

  assign word_valid_o    = wv_q;
  assign word_data_o     = wd_q;
  assign word_ts_start_o = wt0_q;
  assign word_ts_end_o   = wt1_q;

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_ITEMS)); // R6

  AST_CFG_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg_i && !cap_i) |=> (cnt_q == '0)); // R10

  AST_WORD_START_NOT_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && ipw_eff == CNT_W'(1) && $stable(ipw_eff)) |-> (word_ts_start_o == word_ts_end_o)); // R9
endmodule

// File: rtl/par_bus_sampler.sv
module par_bus_sampler #(
  parameter int DATA_W    = 8,
  parameter int MAX_ITEMS = 4,
  parameter int TS_W      = 32,
  localparam int IPW_W    = $clog2(MAX_ITEMS + 1),
  localparam int WORD_W   = DATA_W * MAX_ITEMS,
  localparam int CFG_W    = IPW_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              clk_present_i,
  input  logic              edge_fall_i,
  input  logic [IPW_W-1:0]  items_per_word_i,
  input  logic              order_msb_first_i,
  output logic              item_valid_o,
  output logic [DATA_W-1:0] item_data_o,
  output logic [TS_W-1:0]   item_ts_start_o,
  output logic [TS_W-1:0]   item_ts_end_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [TS_W-1:0]   word_ts_start_o,
  output logic [TS_W-1:0]   word_ts_end_o
);
  logic [DATA_W:0]   sync_bus;
  logic              cap;
  logic [DATA_W-1:0] cap_data;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              cfg_chg;

  psw_sync #(.W(DATA_W + 1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({bus_clk_i, bus_data_i}),
    .sync_o  (sync_bus)
  );

  psw_capture_detect #(.DATA_W(DATA_W)) u_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_clk_i     (sync_bus[DATA_W]),
    .smp_data_i    (sync_bus[DATA_W-1:0]),
    .clk_present_i (clk_present_i),
    .edge_fall_i   (edge_fall_i),
    .cap_o         (cap),
    .cap_data_o    (cap_data)
  );

  always_comb begin
    ts_d    = ts_q + 1'b1;
    cfg_now = {clk_present_i, edge_fall_i, order_msb_first_i, items_per_word_i};
    cfg_chg = (cfg_now != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q  <= '0;
      cfg_q <= '0;
    end else begin
      ts_q  <= ts_d;
      cfg_q <= cfg_now;
    end
  end

  psw_item_hold #(.DATA_W(DATA_W), .TS_W(TS_W)) u_item (
    .clk             (clk),
    .rst_n           (rst_n),
    .cap_i           (cap),
    .cap_data_i      (cap_data),
    .ts_i            (ts_q),
    .item_valid_o    (item_valid_o),
    .item_data_o     (item_data_o),
    .item_ts_start_o (item_ts_start_o),
    .item_ts_end_o   (item_ts_end_o)
  );

  psw_word_pack #(.DATA_W(DATA_W), .MAX_ITEMS(MAX_ITEMS), .TS_W(TS_W)) u_pack (
    .clk             (clk),
    .rst_n           (rst_n),
    .cap_i           (cap),
    .cap_data_i      (cap_data),
    .ts_i            (ts_q),
    .ipw_i           (items_per_word_i),
    .order_i         (order_msb_first_i),
    .cfg_chg_i       (cfg_chg),
    .word_valid_o    (word_valid_o),
    .word_data_o     (word_data_o),
    .word_ts_start_o (word_ts_start_o),
    .word_ts_end_o   (word_ts_end_o)
  );

  AST_ITEM_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid_o |-> $past(cap)); // R5

  AST_WORD_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(cap)); // R6

  AST_WORD_END_MATCHES_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && item_valid_o) |-> (word_ts_end_o == item_ts_end_o)); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!item_valid_o && !word_valid_o)); // R11
endmodule

// File: tb/par_bus_sampler_bench.sv
`timescale 1ns/1ps
module par_bus_sampler_bench;
  localparam int HOLD = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk;
  logic [7:0]  bdata;
  logic        present, efall, order;
  logic [2:0]  ipw;
  logic        item_valid_o, word_valid_o;
  logic [7:0]  item_data_o;
  logic [31:0] item_ts_start_o, item_ts_end_o;
  logic [31:0] word_data_o, word_ts_start_o, word_ts_end_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_drive;

  logic [31:0] idat [16];
  int          ispan [16];
  int          icyc [16];
  int          ni;
  logic [31:0] wdat [16];
  int          wspan [16];
  int          wcyc [16];
  int          nw;
  int          c [8];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  par_bus_sampler u_par_bus_sampler (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_data_i(bdata),
    .clk_present_i(present), .edge_fall_i(efall), .items_per_word_i(ipw),
    .order_msb_first_i(order),
    .item_valid_o(item_valid_o), .item_data_o(item_data_o),
    .item_ts_start_o(item_ts_start_o), .item_ts_end_o(item_ts_end_o),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o),
    .word_ts_start_o(word_ts_start_o), .word_ts_end_o(word_ts_end_o)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (item_valid_o && ni < 16) begin
        idat[ni]  = {24'h0, item_data_o};
        ispan[ni] = int'(item_ts_end_o - item_ts_start_o);
        icyc[ni]  = cyc;
        ni = ni + 1;
      end
      if (word_valid_o && nw < 16) begin
        wdat[nw]  = word_data_o;
        wspan[nw] = int'(word_ts_end_o - word_ts_start_o);
        wcyc[nw]  = cyc;
        nw = nw + 1;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset(input logic p, input logic e, input logic o, input logic [2:0] n);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; bdata = 8'h00;
    present = p; efall = e; order = o; ipw = n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ni = 0; nw = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic put(input logic bc, input logic [7:0] bd);
    @(negedge clk);
    bclk = bc; bdata = bd; last_drive = cyc;
    repeat (HOLD - 1) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; bdata = 8'h00;
    present = 1'b0; efall = 1'b0; order = 1'b0; ipw = 3'd1;
    repeat (2) @(negedge clk);
    chk("R11 item_valid in reset", longint'(item_valid_o), 0);
    chk("R11 word_valid in reset", longint'(word_valid_o), 0);
    @(negedge clk);
    rst_n = 1'b1; ni = 0; nw = 0;
    repeat (3) @(negedge clk);
    put(1'b0, 8'h3C); c[0] = last_drive;
    settle();
    chk("R11 no item after first capture", ni, 0);
    chk("R12 word latency", wcyc[0] - c[0], 3);
    put(1'b0, 8'hC3); c[1] = last_drive;
    settle();
    chk("R12 single item strobe", ni, 1);
    chk("R12 item latency", icyc[0] - c[1], 3);
    chk("R5 held item value", idat[0], 32'h3C);
    chk("R5 held item span", ispan[0], c[1] - c[0]);
  endtask

  task automatic t_rising();
    do_reset(1'b1, 1'b0, 1'b0, 3'd1);
    put(1'b1, 8'h11); c[0] = last_drive;
    put(1'b1, 8'h11);
    put(1'b0, 8'h22);
    put(1'b0, 8'h23);
    put(1'b1, 8'h23); c[1] = last_drive;
    put(1'b0, 8'h23);
    put(1'b1, 8'h44); c[2] = last_drive;
    settle();
    chk("R2 rising capture count", nw, 3);
    chk("R1 identical sample ignored (item count)", ni, 2);
    chk("R2 word 0", wdat[0], 32'h11);
    chk("R2 word 1", wdat[1], 32'h23);
    chk("R2 word 2", wdat[2], 32'h44);
    chk("R5 item 0 value", idat[0], 32'h11);
    chk("R5 item 0 span", ispan[0], c[1] - c[0]);
    chk("R5 item 1 span", ispan[1], c[2] - c[1]);
    chk("R9 single-item word span", wspan[1], 0);
  endtask

  task automatic t_falling();
    do_reset(1'b1, 1'b1, 1'b0, 3'd1);
    put(1'b1, 8'h05);
    put(1'b0, 8'h05);
    put(1'b1, 8'h06);
    put(1'b0, 8'h07);
    put(1'b1, 8'h07);
    put(1'b0, 8'h80);
    settle();
    chk("R3 falling capture count", nw, 3);
    chk("R3 word 0", wdat[0], 32'h05);
    chk("R3 word 1", wdat[1], 32'h07);
    chk("R3 word 2", wdat[2], 32'h80);
  endtask

  task automatic t_clockless();
    do_reset(1'b0, 1'b0, 1'b0, 3'd1);
    put(1'b0, 8'h01);
    put(1'b1, 8'h01);
    put(1'b0, 8'h01);
    put(1'b0, 8'h80);
    put(1'b1, 8'hA5);
    put(1'b1, 8'hA5);
    settle();
    chk("R4 data-change capture count", nw, 3);
    chk("R4 word 0 (R5 line 0 to bit 0)", wdat[0], 32'h01);
    chk("R4 word 1 (R5 line 7 to bit 7)", wdat[1], 32'h80);
    chk("R4 word 2", wdat[2], 32'hA5);
    chk("R5 clockless item 1", idat[1], 32'h80);
  endtask

  task automatic t_pack();
    do_reset(1'b0, 1'b0, 1'b1, 3'd3);
    for (int i = 0; i < 6; i++) begin
      put(1'b0, 8'((i + 1) * 8'h11)); c[i] = last_drive;
    end
    settle();
    chk("R7 msb-first word count", nw, 2);
    chk("R7 msb-first word 0", wdat[0], 32'h00112233);
    chk("R7 msb-first word 1", wdat[1], 32'h00445566);
    chk("R9 word 0 span", wspan[0], c[2] - c[0]);
    chk("R9 word 1 span", wspan[1], c[5] - c[3]);
    do_reset(1'b0, 1'b0, 1'b0, 3'd4);
    for (int i = 0; i < 4; i++) begin
      put(1'b0, 8'((i + 1) * 8'h11)); c[i] = last_drive;
    end
    settle();
    chk("R8 lsb-first word count", nw, 1);
    chk("R8 lsb-first word", wdat[0], 32'h44332211);
    chk("R9 four-item span", wspan[0], c[3] - c[0]);
  endtask

  task automatic t_clamp();
    do_reset(1'b0, 1'b0, 1'b0, 3'd0);
    put(1'b0, 8'h09);
    put(1'b0, 8'h0A);
    settle();
    chk("R6 ipw 0 read as 1", nw, 2);
    chk("R6 ipw 0 word 1", wdat[1], 32'h0A);
    do_reset(1'b0, 1'b0, 1'b0, 3'd7);
    for (int i = 1; i <= 5; i++) put(1'b0, 8'(i));
    settle();
    chk("R6 ipw 7 read as 4", nw, 1);
    chk("R6 ipw 7 word", wdat[0], 32'h04030201);
  endtask

  task automatic t_cfg();
    do_reset(1'b0, 1'b0, 1'b0, 3'd2);
    put(1'b0, 8'h10);
    @(negedge clk);
    order = 1'b1;
    repeat (4) @(negedge clk);
    put(1'b0, 8'h20);
    put(1'b0, 8'h30);
    settle();
    chk("R10 words after config change", nw, 1);
    chk("R10 pending item dropped", wdat[0], 32'h2030);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; bdata = 8'h00;
    present = 1'b0; efall = 1'b0; order = 1'b0; ipw = 3'd1;
    ni = 0; nw = 0; last_drive = 0;
    t_reset();
    t_rising();
    t_falling();
    t_clockless();
    t_pack();
    t_clamp();
    t_cfg();
    summary();
  end
endmodule